// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block produces the slow timekeeping clock of an always-on domain. It runs from a fast internal RC oscillator. A fixed power-of-two stage brings that oscillator down to an intermediate rate. A programmable divide-by-(N+1) stage then brings it to roughly 32 kHz. A source-select bit can route an external crystal oscillator input straight to the output in place of the divided internal path. A separate gate bit passes the selected clock to a second output pin, which feeds other devices.

The control register is protected against stray writes. A write to it is accepted only when the upper half-word of the data carries the key value 0x16AA. Three bits of the control register are read-only busy flags that come from the calendar logic. The control register also drives an enable for the external oscillator and a bit that turns off automatic fallback to the internal oscillator. Both are brought out as pins. The prescaler and gate registers need no key. All registers sit on a simple register bus: address, write data, write strobe and read data. The bus is clocked by the RC oscillator.

Top module: `slow_clk_sel`

## Requirements
- R1: After reset, all three registers read 0 (apart from the busy flags, which follow `busy_i`). The internal path is selected, `gated_clk_o` is low, and `osc_ext_en_o` and `fallback_off_o` are low.
- R2: A write to offset 0x00 updates bit 0 (source select), bit 4 (external oscillator enable) and bit 15 (fallback off) only when write data [31:16] equals 0x16AA. Any other key leaves all three bits unchanged.
- R3: Offset 0x00 reads `busy_i[2:0]` at bits [9:7], and a write cannot change these bits. Bits [31:16] and every other unassigned bit read 0.
- R4: With source select 1, `slow_clk_o` follows `osc_ext_i` with no register delay. With source select 0, `slow_clk_o` carries the divided internal clock.
- R5: On the internal path, the period of `slow_clk_o` is FIX_DIV × (N+1) RC cycles, where N is the prescaler value.
- R6: For a ratio R = N+1 above 1, the output is high for FIX_DIV × ceil(R/2) RC cycles per period. For even R this gives exactly 50% duty.
- R7: With N = 0, the output is the fixed stage's square wave: period FIX_DIV, high for FIX_DIV/2.
- R8: Bit 0 of offset 0x60 set to 1 makes `gated_clk_o` follow `slow_clk_o`. With the bit at 0, `gated_clk_o` stays low.
- R9: Offset 0x08 holds a PRE_W-bit prescaler in its low bits, and offset 0x60 holds one bit at bit 0. Upper bits of both are dropped on write and read as 0. Neither register needs a key.
- R10: `osc_ext_en_o` reflects control bit 4, and `fallback_off_o` reflects control bit 15.
- R11: A write to an offset other than 0x00, 0x08 or 0x60 changes no register, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc_i | input | 1 | Internal RC oscillator; clocks the dividers and the registers |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| busy_i | input | 3 | Busy flags from the calendar logic |
| osc_ext_i | input | 1 | External crystal oscillator |
| osc_ext_en_o | output | 1 | Enable for the external oscillator |
| fallback_off_o | output | 1 | Turns off automatic fallback to the internal oscillator |
| slow_clk_o | output | 1 | Selected slow clock |
| gated_clk_o | output | 1 | Slow clock gated onto the output pin |

## Verification
The bench builds the block with FIX_DIV = 4 and the default 5-bit prescaler. A full output period is then at most 128 RC cycles, so every ratio class can be measured in a few hundred cycles. The classes are: ratio 1 pass-through, the smallest even and odd ratios, a mid-range odd ratio, and the two largest ratios 31 and 32. With the default FIX_DIV of 32, the same divider logic would need thousands of cycles per measurement. The reduced fixed stage keeps the counter wrap and the carry into the programmable stage at their real boundaries.

// File: rtl/slck_pkg.sv
package slck_pkg;
  localparam int          CTRL_ADDR = 'h00;
  localparam int          PRE_ADDR  = 'h08;
  localparam int          GATE_ADDR = 'h60;
  localparam logic [15:0] CTRL_KEY  = 16'h16AA;
  localparam int          CB_SEL    = 0;
  localparam int          CB_EXTEN  = 4;
  localparam int          CB_BYP    = 15;
  localparam int          BUSY_W    = 3;
endpackage

// File: rtl/slck_regs.sv
module slck_regs
  import slck_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic [BUSY_W-1:0] busy,
  output logic [31:0]       bus_rdata,
  output logic              sel_o,
  output logic              ext_en_o,
  output logic              byp_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic              gate_o
);
  logic             sel_q, ext_q, byp_q, gate_q;
  logic             sel_d, ext_d, byp_d, gate_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             hit_ctrl, hit_pre, hit_gate, key_ok;
  logic             ctrl_en, pre_en, gate_en;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    hit_ctrl = bus_addr == ADDR_W'(CTRL_ADDR);
    hit_pre  = bus_addr == ADDR_W'(PRE_ADDR);
    hit_gate = bus_addr == ADDR_W'(GATE_ADDR);
    key_ok   = bus_wdata[31:16] == CTRL_KEY;
    ctrl_en  = bus_wr && hit_ctrl && key_ok;
    pre_en   = bus_wr && hit_pre;
    gate_en  = bus_wr && hit_gate;
    sel_d    = bus_wdata[CB_SEL];
    ext_d    = bus_wdata[CB_EXTEN];
    byp_d    = bus_wdata[CB_BYP];
    pre_d    = bus_wdata[PRE_W-1:0];
    gate_d   = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      ext_q  <= 1'b0;
      byp_q  <= 1'b0;
      pre_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (ctrl_en) begin
        sel_q <= sel_d;
        ext_q <= ext_d;
        byp_q <= byp_d;
      end
      if (pre_en)  pre_q  <= pre_d;
      if (gate_en) gate_q <= gate_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CB_SEL]   = sel_q;
      bus_rdata[CB_EXTEN] = ext_q;
      bus_rdata[CB_BYP]   = byp_q;
      bus_rdata[9:7]      = busy;
    end else if (hit_pre) begin
      bus_rdata[PRE_W-1:0] = pre_q;
    end else if (hit_gate) begin
      bus_rdata[0] = gate_q;
    end
  end

  assign sel_o    = sel_q;
  assign ext_en_o = ext_q;
  assign byp_o    = byp_q;
  assign pre_o    = pre_q;
  assign gate_o   = gate_q;

  // R2: a control write with a wrong key leaves the control bits alone
  p_bad_key_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_ctrl && !key_ok) |=> ($stable(sel_q) && $stable(ext_q) && $stable(byp_q)));

  // R2: a keyed control write lands in the next cycle
  p_keyed_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_ctrl && key_ok) |=> (sel_q == $past(bus_wdata[CB_SEL]) &&
                                        byp_q == $past(bus_wdata[CB_BYP])));

  // R11: the prescaler only moves on a write to its own offset
  p_pre_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_pre) |=> $stable(pre_q));
endmodule

// File: rtl/slck_fixdiv.sv
module slck_fixdiv #(
  parameter int FIX_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic sq_o
);
  generate
    if (FIX_DIV == 1) begin : g_bypass
      assign tick_o = 1'b1;
      assign sq_o   = clk;
    end else begin : g_count
      localparam int CNT_W = $clog2(FIX_DIV);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb cnt_d = cnt_q + 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = &cnt_q;
      assign sq_o   = cnt_q[CNT_W-1];

      // R5: the fixed stage never emits two ticks back to back
      p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/slck_progdiv.sv
module slck_progdiv #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         fix_sq_i,
  input  logic [W-1:0] ratio_m1_i,
  output logic         clk_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         out_q, out_d;
  logic [W:0]   half;

  always_comb begin
    cnt_d = (cnt_q >= ratio_m1_i) ? '0 : cnt_q + 1'b1;
    half  = ({1'b0, ratio_m1_i} + (W+1)'(2)) >> 1;
    out_d = {1'b0, cnt_d} < half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_o = (ratio_m1_i == '0) ? fix_sq_i : out_q;

  // R5: the divided output only moves on a tick from the fixed stage
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(out_q));
endmodule

// File: rtl/slow_clk_sel.sv
module slow_clk_sel
  import slck_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PRE_W   = 5,
  parameter int FIX_DIV = 32
) (
  input  logic              clk_rc_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_wr_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [2:0]        busy_i,
  input  logic              osc_ext_i,
  output logic              osc_ext_en_o,
  output logic              fallback_off_o,
  output logic              slow_clk_o,
  output logic              gated_clk_o
);
  logic             rst_meta_q, rst_sync_q;
  logic             sel, gate, tick, fix_sq, int_clk;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk_rc_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  slck_regs #(.ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_regs (
    .clk       (clk_rc_i),
    .rst_n     (rst_sync_q),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .bus_wr    (bus_wr_i),
    .busy      (busy_i),
    .bus_rdata (bus_rdata_o),
    .sel_o     (sel),
    .ext_en_o  (osc_ext_en_o),
    .byp_o     (fallback_off_o),
    .pre_o     (pre),
    .gate_o    (gate)
  );

  slck_fixdiv #(.FIX_DIV(FIX_DIV)) u_fix (
    .clk    (clk_rc_i),
    .rst_n  (rst_sync_q),
    .tick_o (tick),
    .sq_o   (fix_sq)
  );

  slck_progdiv #(.W(PRE_W)) u_prog (
    .clk        (clk_rc_i),
    .rst_n      (rst_sync_q),
    .tick_i     (tick),
    .fix_sq_i   (fix_sq),
    .ratio_m1_i (pre),
    .clk_o      (int_clk)
  );

  assign slow_clk_o  = sel ? osc_ext_i : int_clk;
  assign gated_clk_o = slow_clk_o & gate;
endmodule

// File: tb/slow_clk_sel_tb.sv
module slow_clk_sel_tb;
  localparam int FD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  busy = '0;
  logic        ext = 1'b0;
  logic        ext_en, fb_off, slow, gated;
  int          errors = 0;
  int          checks = 0;

  // prescaler N [23:16], expected period [15:8], expected high [7:0] for FD = 4
  localparam logic [23:0] VEC [8] = '{
    24'h00_04_02, 24'h01_08_04, 24'h02_0C_08, 24'h03_10_08,
    24'h04_14_0C, 24'h06_1C_10, 24'h1E_7C_40, 24'h1F_80_40
  };

  always #2.5 clk = ~clk;

  slow_clk_sel #(.ADDR_W(8), .PRE_W(5), .FIX_DIV(FD)) u_dut (
    .clk_rc_i(clk), .rst_n_i(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rdata_o(rdata), .busy_i(busy), .osc_ext_i(ext),
    .osc_ext_en_o(ext_en), .fallback_off_o(fb_off), .slow_clk_o(slow),
    .gated_clk_o(gated)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic measure(input logic src_gated, output int per, output int hi);
    logic prev, cur, rose;
    int guard = 0;
    prev = src_gated ? gated : slow;
    rose = 1'b0;
    while (!rose && guard < 1000) begin
      @(negedge clk); cur = src_gated ? gated : slow;
      rose = !prev && cur; prev = cur; guard++;
    end
    per = 0; hi = 0; rose = 1'b0;
    while (!rose && guard < 2000) begin
      if (cur) hi++;
      per++;
      @(negedge clk); cur = src_gated ? gated : slow;
      rose = !prev && cur; prev = cur; guard++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int per, hi, highs;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_read(8'h00, d); chk("R1 ctrl", d, 32'h0);
    bus_read(8'h08, d); chk("R1 pre", d, 32'h0);
    bus_read(8'h60, d); chk("R1 gate", d, 32'h0);
    chk("R1 ext_en", {31'h0, ext_en}, 32'h0);
    chk("R1 fallback", {31'h0, fb_off}, 32'h0);
    highs = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (gated) highs++; end
    chk("R1 gated low", highs, 0);
    measure(1'b0, per, hi);
    chk("R1 internal path period", per, FD);

    // R3: busy flags at [9:7], not writable
    busy = 3'b101;
    bus_read(8'h00, d); chk("R3 busy read", d, 32'h0000_0280);
    bus_write(8'h00, 32'h16AA_0380);
    bus_read(8'h00, d); chk("R3 busy not written", d, 32'h0000_0280);
    busy = 3'b000;
    bus_read(8'h00, d); chk("R3 busy cleared", d, 32'h0);

    // R2: wrong key ignored, right key accepted
    bus_write(8'h00, 32'h16AB_8011);
    bus_read(8'h00, d); chk("R2 bad key ignored", d, 32'h0);
    chk("R2 bad key ext_en", {31'h0, ext_en}, 32'h0);
    bus_write(8'h00, 32'h0000_8011);
    bus_read(8'h00, d); chk("R2 zero key ignored", d, 32'h0);
    bus_write(8'h00, 32'h16AA_8011);
    bus_read(8'h00, d); chk("R2 keyed write", d, 32'h0000_8011);
    chk("R10 ext_en", {31'h0, ext_en}, 32'h1);
    chk("R10 fallback", {31'h0, fb_off}, 32'h1);

    // R4: external source routed directly; R8 gate closed
    @(negedge clk); ext = 1'b1; #1;
    chk("R4 ext high", {31'h0, slow}, 32'h1);
    chk("R8 gate closed", {31'h0, gated}, 32'h0);
    @(negedge clk); ext = 1'b0; #1;
    chk("R4 ext low", {31'h0, slow}, 32'h0);

    // R8 gate open; R9 gate register width
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_read(8'h60, d); chk("R9 gate readback", d, 32'h1);
    @(negedge clk); ext = 1'b1; #1;
    chk("R8 gated follows high", {31'h0, gated}, 32'h1);
    @(negedge clk); ext = 1'b0; #1;
    chk("R8 gated follows low", {31'h0, gated}, 32'h0);

    // R11: undefined offsets
    bus_write(8'h04, 32'h16AA_0000);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h00, d); chk("R11 ctrl kept", d, 32'h0000_8011);
    bus_read(8'h08, d); chk("R11 pre kept", d, 32'h0);
    bus_read(8'h60, d); chk("R11 gate kept", d, 32'h1);
    bus_read(8'h04, d); chk("R11 hole reads 0", d, 32'h0);

    // R9: prescaler width
    bus_write(8'h08, 32'hFFFF_FFE3);
    bus_read(8'h08, d); chk("R9 pre readback", d, 32'h3);

    // back to internal path
    bus_write(8'h00, 32'h16AA_0000);
    chk("R10 ext_en off", {31'h0, ext_en}, 32'h0);

    // R5/R6/R7: ratio table
    foreach (VEC[k]) begin
      bus_write(8'h08, {27'h0, VEC[k][20:16]});
      measure(1'b0, per, hi);
      measure(1'b0, per, hi);
      chk("R5 period", per, int'(VEC[k][15:8]));
      if (VEC[k][20:16] == 5'd0) chk("R7 ratio1 high", hi, int'(VEC[k][7:0]));
      else                       chk("R6 high time", hi, int'(VEC[k][7:0]));
    end

    // R8: gated copy of the internal clock
    measure(1'b1, per, hi);
    chk("R8 gated period", per, 128);
    bus_write(8'h60, 32'h0);
    highs = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (gated) highs++; end
    chk("R8 gate closed internal", highs, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule